// File: doc/BRIEF.md
# Five-Port Round-Robin Switch Allocator and Crossbar

This block is the switch traversal stage of a five-port on-chip router. Every input presents a request valid, a 3-bit target output number and a flit. Each output owns a rotating-priority arbiter that picks one of the inputs asking for it. An encoder then turns the winning input into a one-hot select vector for that output. A multiplexer crossbar steers the selected flit into a registered output slot.

In the same cycle as the grant, the block drives an active-low credit back to every input that won. The input buffer upstream uses this credit to free the slot of the flit that was sent. Route computation and input buffering are done elsewhere. The block only decides who crosses the switch and moves the data.

Top module: `rrSwitchXbar`

## Requirements
- R1: After reset, every outValid bit is 0, every outFlit word is 0, and every output's priority pointer points at input 0.
- R2: Input i requests output o only when reqValid[i] is 1 and its target field reqTarget[3i+2:3i] equals o. A target value of 5, 6 or 7 matches no output, is never granted, and leaves creditN[i] at 1.
- R3: The input that has just been granted an output has the lowest priority for that output on the next cycle. An output's pointer moves only in a cycle where that output issues a grant.
- R4: Inputs that compete for the same output are granted one per cycle in turn. Requests 00011 to output 0 from reset give grant 00001 and then 00010.
- R5: In any cycle, each output selects at most one input, and each input receives at most one grant.
- R6: creditN is active low. It is the bitwise inverse of the per-input grant vector and is valid in the same cycle as the request (grant 10000 gives creditN 01111).
- R7: One clock edge after output o grants input i, outValid[o] is 1 and outFlit word o holds flit i as it was in the grant cycle.
- R8: When output o grants nothing, outValid[o] is 0 after the next edge and outFlit word o keeps its previous value.
- R9: Requests aimed at different outputs are all granted in the same cycle.
- R10: An input that requests one output without a break waits for no more than four grants to other inputs before it is served.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reqValid | input | 5 | Per-input request valid |
| reqTarget | input | 15 | Per-input 3-bit target output number; input i uses bits [3i+2:3i] |
| flitIn | input | 5*FLIT_W | Per-input flit; input i uses word i |
| outFlit | output | 5*FLIT_W | Registered output flits; output o uses word o |
| outValid | output | 5 | Registered per-output valid |
| creditN | output | 5 | Per-input credit, active low, combinational |

## Verification
Several rules are checked by assertions on every cycle: no grant goes to a non-requesting input, each output's grant and select vectors are at most one-hot, the number of credits given equals the number of outputs that fire, and an output whose valid is low holds its flit. The assertions also check that a repeated winner never appears while another input is still competing, and that a pointer stays put when nothing is requested. Other behaviours can only be shown by the bench's scenarios. These are the exact grant order from a known pointer state, the return of the pointers to input 0 after a mid-run reset, the four-grant waiting bound under full contention, and the rejection of out-of-range targets.

// File: rtl/swx_pkg.sv
package swx_pkg;
  localparam int NPORT  = 5;
  localparam int PIDX_W = $clog2(NPORT);

  typedef logic [NPORT-1:0] portVec_t;

  // Strobes from control to datapath
  typedef struct packed {
    portVec_t [NPORT-1:0] sel;   // per output: one-hot input select
    portVec_t             fire;  // per output: a flit crosses this cycle
  } xbarStrobe_t;
endpackage

// File: rtl/swRrArb.sv
module swRrArb #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;

  logic [IW-1:0] ptr;
  logic [IW-1:0] winIdx;
  logic          hit;
  int            cIdx;

  // Scan from the pointer around the ring; first requester wins
  always_comb begin
    gnt    = '0;
    hit    = 1'b0;
    winIdx = ptr;
    cIdx   = 0;
    for (int k = 0; k < N; k++) begin
      cIdx = (int'(ptr) + k) % N;
      if (!hit && req[cIdx]) begin
        hit         = 1'b1;
        winIdx      = IW'(cIdx);
        gnt[cIdx]   = 1'b1;
      end
    end
  end

  // Winner drops to lowest priority; pointer moves only on a grant
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   ptr <= '0;
    else if (hit) ptr <= (winIdx == IW'(N - 1)) ? '0 : winIdx + IW'(1);
  end

  // R2: grants only to requesters
  a_r2_gnt_within_req: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt & ~req) == '0);
  // R5: one winner at most
  a_r5_gnt_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));
  // R3: a winner is not chosen again while someone else competes
  a_r3_rotate: assert property (@(posedge clk) disable iff (!rst_n)
    (|gnt) |=> !((gnt == $past(gnt)) && ($countones(req) > 1)));
  // R3: no request, no pointer movement
  a_r3_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (req == '0) |=> $stable(ptr));
endmodule

// File: rtl/swCtrl.sv
module swCtrl
  import swx_pkg::*;
(
  input  logic                            clk,
  input  logic                            rst_n,
  input  portVec_t                        reqValid,
  input  logic [NPORT-1:0][PIDX_W-1:0]    reqTarget,
  output xbarStrobe_t                     strobe,
  output portVec_t                        creditN
);
  portVec_t reqForOut [NPORT];
  portVec_t gntOut    [NPORT];
  portVec_t grantIn;

  // Route decode: which inputs want which output
  always_comb begin
    for (int o = 0; o < NPORT; o++)
      for (int i = 0; i < NPORT; i++)
        reqForOut[o][i] = reqValid[i] && (reqTarget[i] == PIDX_W'(o));
  end

  for (genvar o = 0; o < NPORT; o++) begin : g_arb
    swRrArb #(.N(NPORT)) u_arb (
      .clk  (clk),
      .rst_n(rst_n),
      .req  (reqForOut[o]),
      .gnt  (gntOut[o])
    );
  end

  // Per-input grant gathered over all outputs
  always_comb begin
    grantIn = '0;
    for (int o = 0; o < NPORT; o++) grantIn = grantIn | gntOut[o];
  end

  // Encoder: grant combined with stored target gives one-hot selects
  always_comb begin
    strobe = '0;
    for (int o = 0; o < NPORT; o++) begin
      for (int i = 0; i < NPORT; i++)
        strobe.sel[o][i] = grantIn[i] && (reqTarget[i] == PIDX_W'(o));
      strobe.fire[o] = |strobe.sel[o];
    end
  end

  assign creditN = ~grantIn;

  for (genvar o = 0; o < NPORT; o++) begin : g_chk
    // R5: one driver per output
    a_r5_sel_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(strobe.sel[o]));
  end
  // R6: one credit per flit crossing
  a_r6_credit_count: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~creditN) == $countones(strobe.fire));
endmodule

// File: rtl/swData.sv
module swData
  import swx_pkg::*;
#(
  parameter int FLIT_W = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NPORT-1:0][FLIT_W-1:0]  flitIn,
  input  xbarStrobe_t                   strobe,
  output logic [NPORT-1:0][FLIT_W-1:0]  outFlit,
  output portVec_t                      outValid
);
  logic [NPORT-1:0][FLIT_W-1:0] muxOut;

  // AND-OR multiplexer per output, steered by the one-hot select
  always_comb begin
    muxOut = '0;
    for (int o = 0; o < NPORT; o++)
      for (int i = 0; i < NPORT; i++)
        if (strobe.sel[o][i]) muxOut[o] = muxOut[o] | flitIn[i];
  end

  // Output registers load only when a flit crosses
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      outValid <= '0;
      outFlit  <= '0;
    end else begin
      outValid <= strobe.fire;
      for (int o = 0; o < NPORT; o++)
        if (strobe.fire[o]) outFlit[o] <= muxOut[o];
    end
  end

  for (genvar o = 0; o < NPORT; o++) begin : g_chk
    // R8: an idle output keeps its flit
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !outValid[o] |-> $stable(outFlit[o]));
  end
endmodule

// File: rtl/rrSwitchXbar.sv
module rrSwitchXbar
  import swx_pkg::*;
#(
  parameter int FLIT_W = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NPORT-1:0]          reqValid,
  input  logic [NPORT*PIDX_W-1:0]   reqTarget,
  input  logic [NPORT*FLIT_W-1:0]   flitIn,
  output logic [NPORT*FLIT_W-1:0]   outFlit,
  output logic [NPORT-1:0]          outValid,
  output logic [NPORT-1:0]          creditN
);
  logic [NPORT-1:0][PIDX_W-1:0] tgtArr;
  logic [NPORT-1:0][FLIT_W-1:0] flitArr;
  logic [NPORT-1:0][FLIT_W-1:0] outArr;
  xbarStrobe_t                  strobe;

  assign tgtArr  = reqTarget;
  assign flitArr = flitIn;
  assign outFlit = outArr;

  swCtrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .reqValid (reqValid),
    .reqTarget(tgtArr),
    .strobe   (strobe),
    .creditN  (creditN)
  );

  swData #(.FLIT_W(FLIT_W)) u_data (
    .clk     (clk),
    .rst_n   (rst_n),
    .flitIn  (flitArr),
    .strobe  (strobe),
    .outFlit (outArr),
    .outValid(outValid)
  );

  // R7: a credit given means a flit appears at an output next cycle
  a_r7_credit_to_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (creditN != '1) |=> (outValid != '0));
endmodule

// File: tb/tb_rrSwitchXbar.sv
module tb_rrSwitchXbar;
  localparam int NP = 5;
  localparam int FW = 32;
  localparam int NV = 16;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [NP-1:0]     reqValid = '0;
  logic [NP*3-1:0]   reqTarget = '0;
  logic [NP*FW-1:0]  flitIn = '0;
  logic [NP*FW-1:0]  outFlit;
  logic [NP-1:0]     outValid;
  logic [NP-1:0]     creditN;

  int total = 0;
  int bad   = 0;
  int stepNo = 0;
  logic [FW-1:0] expFlit [NP];

  always #5 clk = ~clk;

  rrSwitchXbar #(.FLIT_W(FW)) dut (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqTarget(reqTarget),
    .flitIn(flitIn), .outFlit(outFlit), .outValid(outValid), .creditN(creditN)
  );

  // Vector table: request, targets (3 bits per input), expected credit
  localparam logic [4:0]  T_REQ [NV] = '{
    5'b00011, 5'b00011, 5'b00011, 5'b00000, 5'b00001, 5'b11111,
    5'b01100, 5'b01100, 5'b10000, 5'b00001,
    5'b11111, 5'b11111, 5'b11111, 5'b11111, 5'b11111, 5'b11111};
  localparam logic [14:0] T_TGT [NV] = '{
    15'h0000, 15'h0000, 15'h0000, 15'h0000, 15'h0000, 15'h4688,
    15'h0240, 15'h0240, 15'h2000, 15'h0005,
    15'h4924, 15'h4924, 15'h4924, 15'h4924, 15'h4924, 15'h4924};
  localparam logic [4:0]  T_CRD [NV] = '{
    5'b11110, 5'b11101, 5'b11110, 5'b11111, 5'b11110, 5'b00000,
    5'b11011, 5'b10111, 5'b01111, 5'b11111,
    5'b11110, 5'b11101, 5'b11011, 5'b10111, 5'b01111, 5'b11110};

  function automatic logic [FW-1:0] flitFor(input int s, input int i);
    return 32'h5A00_0000 | FW'(s << 8) | FW'(i);
  endfunction

  task automatic check(input logic ok, input string what,
                       input logic [FW-1:0] act, input logic [FW-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  // Called at a falling edge; returns at the next falling edge
  task automatic runStep(input logic [4:0] req, input logic [14:0] tgt,
                         input logic [4:0] expCred);
    logic [NP-1:0] expV;
    stepNo++;
    reqValid  = req;
    reqTarget = tgt;
    for (int i = 0; i < NP; i++) flitIn[i*FW +: FW] = flitFor(stepNo, i);
    #1;
    check(creditN == expCred, "R2 R3 R4 R6 R9 creditN",
          FW'(creditN), FW'(expCred));
    expV = '0;
    for (int i = 0; i < NP; i++)
      if (!expCred[i]) begin
        expV[tgt[3*i +: 3]]    = 1'b1;
        expFlit[tgt[3*i +: 3]] = flitFor(stepNo, i);
      end
    @(posedge clk); #1;
    check(outValid == expV, "R7 R8 outValid", FW'(outValid), FW'(expV));
    for (int o = 0; o < NP; o++)
      check(outFlit[o*FW +: FW] == expFlit[o], "R5 R7 R8 outFlit",
            outFlit[o*FW +: FW], expFlit[o]);
    @(negedge clk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int waits [NP];
    int maxWait;
    int winner;
    for (int o = 0; o < NP; o++) expFlit[o] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1: reset state
    check(outValid == '0, "R1 outValid", FW'(outValid), 0);
    check(outFlit == '0, "R1 outFlit", outFlit[FW-1:0], 0);
    check(creditN == '1, "R6 idle creditN", FW'(creditN), FW'(5'b11111));
    @(negedge clk);

    // Table walk: contention (R4), idle hold (R8), parallel (R9),
    // out-of-range target (R2), full rotation (R3)
    for (int v = 0; v < NV; v++) runStep(T_REQ[v], T_TGT[v], T_CRD[v]);

    // R10: all five inputs on output 0; pointer of output 0 is at input 1
    for (int i = 0; i < NP; i++) waits[i] = 0;
    maxWait = 0;
    for (int k = 0; k < 17; k++) begin
      reqValid  = 5'b11111;
      reqTarget = '0;
      #1;
      winner = -1;
      for (int i = 0; i < NP; i++) if (!creditN[i]) winner = i;
      check($countones(~creditN) == 1, "R5 single grant",
            FW'(~creditN), 1);
      check(winner == (1 + k) % NP, "R3 rotation order",
            FW'(winner), FW'((1 + k) % NP));
      for (int i = 0; i < NP; i++) begin
        if (i == winner) waits[i] = 0;
        else begin
          waits[i]++;
          if (waits[i] > maxWait) maxWait = waits[i];
        end
      end
      @(posedge clk);
      @(negedge clk);
    end
    check(maxWait <= 4, "R10 max wait", FW'(maxWait), 4);

    // R1: mid-run reset returns pointers to input 0
    reqValid = '0;
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check(outValid == '0, "R1 outValid after reset", FW'(outValid), 0);
    check(outFlit == '0, "R1 outFlit after reset", outFlit[FW-1:0], 0);
    for (int o = 0; o < NP; o++) expFlit[o] = '0;
    @(negedge clk);
    // Output 0 pointer was left at input 3; from reset input 1 must win
    runStep(5'b10010, 15'h0000, 5'b11101);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule